// File: doc/BRIEF.md
# Word Stack Push/Pop Engine

This block moves 16-bit words onto and off a downward-growing stack that lives in a byte-wide memory. The stack is located by a 16-bit segment value and a 16-bit stack pointer held inside the block. The byte address is the segment shifted left four places plus the pointer offset, truncated to 20 bits.

A push request stores the supplied word as two byte writes in consecutive cycles. The upper byte goes out first, to the higher address, and the pointer then drops by two. A pop request reads the two bytes in the opposite order and returns them as one word, and the pointer then rises by two. A one-cycle done strobe marks the end of each operation.

The memory is expected to present read data for the address shown in a cycle before the next rising clock edge. The segment and the push word are captured when a request is accepted, so the caller may change them while the operation runs.

Top module: `stack_engine`

## Requirements
- R1: After reset the stack pointer equals the parameter SP_RESET (default 16'h0001), done is 0, and neither mem_we nor mem_rd is asserted.
- R2: Every memory address equals ({segment, 4'b0000} + offset) modulo 2^20, where segment is the stack_seg value captured when the request was accepted.
- R3: A push accepted at a clock edge writes the upper byte of the word to offset SP-1 in the first cycle after that edge, and the lower byte to offset SP-2 in the second cycle.
- R4: At the edge that ends the second push cycle, the stack pointer decreases by 2 and done is 1 for exactly the following cycle.
- R5: A pop reads offset SP in the first cycle after acceptance, taken as the lower byte, and offset SP+1 in the second cycle, taken as the upper byte. pop_data then equals {upper, lower}.
- R6: At the edge that ends the second pop cycle, the stack pointer increases by 2, pop_data is updated, and done is 1 for exactly the following cycle.
- R7: push_req and pop_req, and changes to push_data and stack_seg, have no effect while an operation is in progress. An operation accepts no new request until it has finished its two memory cycles.
- R8: When push_req and pop_req are both high in an idle cycle, the push is carried out and the pop is dropped.
- R9: The stack pointer and the offsets SP-1, SP-2 and SP+1 wrap modulo 2^16 within the segment.
- R10: mem_we and mem_rd are never high in the same cycle. Both are low whenever no operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_req | input | 1 | Request to push push_data |
| pop_req | input | 1 | Request to pop a word |
| push_data | input | 16 | Word to push, captured on acceptance |
| stack_seg | input | 16 | Stack segment, captured on acceptance |
| mem_addr | output | 20 | Byte address to memory |
| mem_we | output | 1 | Byte write strobe |
| mem_wdata | output | 8 | Byte written to memory |
| mem_rd | output | 1 | Byte read strobe |
| mem_rdata | input | 8 | Byte returned for mem_addr in the same cycle |
| pop_data | output | 16 | Most recently popped word |
| sp | output | 16 | Current stack pointer |
| done | output | 1 | One-cycle strobe at the end of each operation |

## Verification
On every cycle, the assertions check the following: the two-cycle ordering of each operation, that a push never yields to a simultaneous pop, and that the pointer changes only at operation end and only by plus or minus two. They also check that read and write strobes never overlap, that done never lasts two cycles, and that the low byte of a push lands one address below the high byte away from the wrap point. Only the bench's scenarios can show some behaviours: that the bytes reaching memory and the words coming back match what was pushed in last-in-first-out order, that segment arithmetic is truncated correctly at the top of the 20-bit space, that the pointer wraps through zero, and that requests and input changes made mid-operation leave the outcome untouched.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int SP_W      = 16;
  localparam int SEG_SHIFT = 4;
  localparam int PA_W      = SP_W + SEG_SHIFT;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 2 * BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_POP_LO,
    ST_POP_HI
  } stk_state_e;

  // Byte address of a stack offset inside a segment.
  function automatic logic [PA_W-1:0] phys_addr(input logic [SP_W-1:0] seg,
                                                input logic [SP_W-1:0] off);
    return {seg, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, off};
  endfunction

  // Pointer moved by a signed step, wrapping within the segment.
  function automatic logic [SP_W-1:0] sp_move(input logic [SP_W-1:0] sp_in,
                                              input int step);
    return sp_in + SP_W'(step);
  endfunction
endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_req,
  input  logic       pop_req,
  output stk_state_e state,
  output logic       ev_accept_push,
  output logic       ev_accept_pop,
  output logic       ev_finish
);
  stk_state_e nxt;

  assign ev_accept_push = (state == ST_IDLE) && push_req;
  assign ev_accept_pop  = (state == ST_IDLE) && !push_req && pop_req;
  assign ev_finish      = (state == ST_PUSH_LO) || (state == ST_POP_HI);

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: begin
        if (ev_accept_push)     nxt = ST_PUSH_HI;
        else if (ev_accept_pop) nxt = ST_POP_LO;
      end
      ST_PUSH_HI: nxt = ST_PUSH_LO;
      ST_PUSH_LO: nxt = ST_IDLE;
      ST_POP_LO:  nxt = ST_POP_HI;
      ST_POP_HI:  nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  // R3: high-byte cycle is always followed by the low-byte cycle
  a_r3_push_order: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_PUSH_HI |=> state == ST_PUSH_LO);
  // R5: low-byte read is always followed by the high-byte read
  a_r5_pop_order: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_POP_LO |=> state == ST_POP_HI);
  // R8: simultaneous requests start a push
  a_r8_push_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && push_req && pop_req) |=> state == ST_PUSH_HI);
  // R7: a finishing operation returns to idle whatever the requests
  a_r7_finish_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |=> state == ST_IDLE);
endmodule

// File: rtl/stk_data.sv
module stk_data
  import stk_pkg::*;
#(
  parameter logic [SP_W-1:0] SP_RESET = 16'h0001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  stk_state_e        state,
  input  logic              ev_accept_push,
  input  logic              ev_accept_pop,
  input  logic              ev_finish,
  input  logic [WORD_W-1:0] push_data,
  input  logic [SP_W-1:0]   stack_seg,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] word_q,
  output logic [SP_W-1:0]   seg_q,
  output logic [SP_W-1:0]   sp_q,
  output logic [WORD_W-1:0] pop_q,
  output logic              done_q
);
  logic [BYTE_W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      seg_q  <= '0;
      sp_q   <= SP_RESET;
      pop_q  <= '0;
      lo_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= ev_finish;
      if (ev_accept_push) word_q <= push_data;
      if (ev_accept_push || ev_accept_pop) seg_q <= stack_seg;
      if (state == ST_POP_LO) lo_q <= mem_rdata;
      if (state == ST_PUSH_LO) sp_q <= sp_move(sp_q, -2);
      if (state == ST_POP_HI) begin
        sp_q  <= sp_move(sp_q, 2);
        pop_q <= {mem_rdata, lo_q};
      end
    end
  end

  // R4: push completion lowers the pointer by two
  a_r4_sp_down: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_PUSH_LO |=> sp_q == $past(sp_q) - 16'd2);
  // R6: pop completion raises the pointer by two
  a_r6_sp_up: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_POP_HI |=> sp_q == $past(sp_q) + 16'd2);
  // R7: pointer holds outside completion cycles
  a_r7_sp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_finish |=> $stable(sp_q));
  // R4: done lasts one cycle
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/stk_bus.sv
module stk_bus
  import stk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  stk_state_e        state,
  input  logic [SP_W-1:0]   seg_q,
  input  logic [SP_W-1:0]   sp_q,
  input  logic [WORD_W-1:0] word_q,
  output logic [PA_W-1:0]   mem_addr,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic              mem_rd
);
  logic [SP_W-1:0] off;

  always_comb begin
    off       = sp_q;
    mem_we    = 1'b0;
    mem_rd    = 1'b0;
    mem_wdata = word_q[BYTE_W-1:0];
    case (state)
      ST_PUSH_HI: begin
        off       = sp_move(sp_q, -1);
        mem_we    = 1'b1;
        mem_wdata = word_q[WORD_W-1:BYTE_W];
      end
      ST_PUSH_LO: begin
        off    = sp_move(sp_q, -2);
        mem_we = 1'b1;
      end
      ST_POP_LO: mem_rd = 1'b1;
      ST_POP_HI: begin
        off    = sp_move(sp_q, 1);
        mem_rd = 1'b1;
      end
      default: ;
    endcase
  end

  assign mem_addr = phys_addr(seg_q, off);

  // R10: read and write strobes never overlap
  a_r10_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_rd));
  // R10: idle means no memory traffic
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE |-> !mem_we && !mem_rd);
  // R3: low byte lands one address below the high byte (away from wrap)
  a_r3_lo_below_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PUSH_LO && sp_q != 16'h0001 && seg_q[SP_W-1 -: SEG_SHIFT] != '1)
      |-> mem_addr == $past(mem_addr) - 20'd1);
endmodule

// File: rtl/stack_engine.sv
module stack_engine
  import stk_pkg::*;
#(
  parameter logic [15:0] SP_RESET = 16'h0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        push_req,
  input  logic        pop_req,
  input  logic [15:0] push_data,
  input  logic [15:0] stack_seg,
  output logic [19:0] mem_addr,
  output logic        mem_we,
  output logic [7:0]  mem_wdata,
  output logic        mem_rd,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] pop_data,
  output logic [15:0] sp,
  output logic        done
);
  stk_state_e        state;
  logic              ev_accept_push;
  logic              ev_accept_pop;
  logic              ev_finish;
  logic [WORD_W-1:0] word_q;
  logic [SP_W-1:0]   seg_q;

  stk_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .push_req       (push_req),
    .pop_req        (pop_req),
    .state          (state),
    .ev_accept_push (ev_accept_push),
    .ev_accept_pop  (ev_accept_pop),
    .ev_finish      (ev_finish)
  );

  stk_data #(.SP_RESET(SP_RESET)) u_data (
    .clk            (clk),
    .rst_n          (rst_n),
    .state          (state),
    .ev_accept_push (ev_accept_push),
    .ev_accept_pop  (ev_accept_pop),
    .ev_finish      (ev_finish),
    .push_data      (push_data),
    .stack_seg      (stack_seg),
    .mem_rdata      (mem_rdata),
    .word_q         (word_q),
    .seg_q          (seg_q),
    .sp_q           (sp),
    .pop_q          (pop_data),
    .done_q         (done)
  );

  stk_bus u_bus (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .seg_q     (seg_q),
    .sp_q      (sp),
    .word_q    (word_q),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rd    (mem_rd)
  );

  // R7: segment captured at acceptance stays fixed during the operation
  a_r7_seg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && !ev_finish) |=> $stable(seg_q));
  // R4 / R6: done follows exactly the completion cycles
  a_r4_done_after_finish: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |=> done);
endmodule

// File: tb/stack_engine_test.sv
module stack_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_req = 1'b0;
  logic        pop_req = 1'b0;
  logic [15:0] push_data = '0;
  logic [15:0] stack_seg = '0;
  logic [19:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic        mem_rd;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] pop_data;
  logic [15:0] sp;
  logic        done;

  int checks = 0;
  int failures = 0;
  int msp = 1;                  // model stack pointer
  logic [15:0] shadow[$];       // model stack contents
  logic [7:0] mem [logic [19:0]];

  always #10 clk = ~clk;        // 50 MHz

  stack_engine uut (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
    .push_data(push_data), .stack_seg(stack_seg), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .pop_data(pop_data), .sp(sp), .done(done)
  );

  // Byte memory: writes land and read data settles mid-cycle.
  always @(negedge clk) begin
    if (mem_we) mem[mem_addr] = mem_wdata;
    mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
  end

  function automatic logic [19:0] pa(int seg, int off);
    return 20'(((seg & 32'hFFFF) * 16 + (off & 32'hFFFF)) % 1048576);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_op(int seg, logic [15:0] data, logic with_pop);
    @(negedge clk);
    chk("R10 idle no strobes", {mem_we, mem_rd}, 0);
    push_req = 1; pop_req = with_pop; push_data = data; stack_seg = 16'(seg);
    @(negedge clk);
    // R7: noise while busy
    push_req = 1; pop_req = 1; push_data = ~data; stack_seg = 16'(seg) ^ 16'h1234;
    chk("R3 R8 hi write strobe", {mem_we, mem_rd}, 2'b10);
    chk("R2 R3 hi address", mem_addr, pa(seg, msp - 1));
    chk("R3 hi byte", mem_wdata, data[15:8]);
    @(negedge clk);
    chk("R3 lo write strobe", {mem_we, mem_rd}, 2'b10);
    chk("R2 R3 R7 lo address", mem_addr, pa(seg, msp - 2));
    chk("R3 R7 lo byte", mem_wdata, data[7:0]);
    chk("R4 done not early", done, 0);
    push_req = 0; pop_req = 0;
    @(negedge clk);
    msp = (msp - 2) & 32'hFFFF;
    chk("R4 R9 sp after push", sp, msp);
    chk("R4 done strobe", done, 1);
    chk("R10 quiet after push", {mem_we, mem_rd}, 0);
    chk("R3 memory hi byte", mem[pa(seg, msp + 1)], data[15:8]);
    chk("R3 memory lo byte", mem[pa(seg, msp)], data[7:0]);
    shadow.push_back(data);
    @(negedge clk);
    chk("R4 done one cycle", done, 0);
  endtask

  task automatic pop_op(int seg);
    logic [15:0] exp;
    @(negedge clk);
    pop_req = 1; stack_seg = 16'(seg);
    @(negedge clk);
    pop_req = 1; push_req = 1; push_data = 16'hDEAD; stack_seg = 16'(seg) ^ 16'h00F0;
    chk("R5 lo read strobe", {mem_we, mem_rd}, 2'b01);
    chk("R2 R5 lo address", mem_addr, pa(seg, msp));
    @(negedge clk);
    chk("R5 hi read strobe", {mem_we, mem_rd}, 2'b01);
    chk("R2 R5 R7 hi address", mem_addr, pa(seg, msp + 1));
    push_req = 0; pop_req = 0;
    @(negedge clk);
    msp = (msp + 2) & 32'hFFFF;
    exp = shadow.pop_back();
    chk("R6 R9 sp after pop", sp, msp);
    chk("R5 R6 popped word", pop_data, exp);
    chk("R6 done strobe", done, 1);
    @(negedge clk);
    chk("R6 done one cycle", done, 0);
    chk("R7 no write from ignored push", {mem_we, mem_rd}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset sp", sp, 16'h0001);
    chk("R1 reset done", done, 0);
    chk("R1 reset strobes", {mem_we, mem_rd}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 sp held after reset", sp, 16'h0001);
    // R9: pointer wraps through zero on push and back on pop
    push_op(16'h2000, 16'hA55A, 1'b0);
    chk("R9 wrapped sp", sp, 16'hFFFF);
    pop_op(16'h2000);
    chk("R9 sp restored", sp, 16'h0001);
    // R2: segment at top of address space truncates
    push_op(16'hFFFF, 16'h1234, 1'b0);
    pop_op(16'hFFFF);
    // R8: simultaneous request pushes
    push_op(16'h0100, 16'hBEEF, 1'b1);
    // LIFO with several words
    push_op(16'h0100, 16'h0011, 1'b0);
    push_op(16'h0100, 16'hFF80, 1'b0);
    pop_op(16'h0100);
    pop_op(16'h0100);
    pop_op(16'h0100);
    chk("R9 final sp", sp, 16'h0001);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule